// File: doc/BRIEF.md
# Privilege-checked memory map controller

This block sits between a processor's byte-wide load/store port and a local RAM. It splits a 16-bit address space into regions and gives each region its own access rights: read-write, read-only or no access. A small set of control bytes sits at the top of the space. These are a 16-bit stack ceiling, the installed memory size, the running tick count and the exit code. All 16-bit values are stored low byte first. There is also a one-byte scratch port that stands in for the I/O window.

Every access is checked in the cycle it is presented. An access that breaks its region's rights does nothing: no byte is written and the read data is 0. Instead the block pulses `fault`, records an exit code and moves from `ST_RUN` to `ST_HALTED`. A stack pointer that reaches a non-zero ceiling also halts the block, with its own exit code.

There are two states, and reset returns the block to `ST_RUN`:
- `ST_RUN` is the normal state. The transition `RUN->HALTED` happens on an access violation or on a stack-ceiling match.
- `ST_HALTED` holds until reset (`HALTED->HALTED`). In this state it only serves reads of the exit-code byte.

Read data, the fault pulse and the exit code are all registered, so they appear one cycle after the access.

Top module: `memmap_guard`

## Requirements
- R1: After reset the block is in `ST_RUN`, `rd_data` is 0x00, `fault` is 0, `exit_code` is 0x00 and the stack ceiling is 0.
- R2: Addresses 0x0002 up to MEM_END (default 0x00FF) read and write RAM. Read data appears one cycle after the read strobe.
- R3: A read of an address with no access rights pulses `fault`, sets exit code 0x01 and returns 0x00. The no-access addresses are 0x0000, 0x0001, MEM_END+1 to 0xFEFF, 0xFF01 to 0xFF7F (the unused part of the I/O window), and 0xFF80 to 0xFFF8.
- R4: A write to a no-access address, or to a read-only byte (0xFFFB to 0xFFFF), pulses `fault`, sets exit code 0x02 and changes no stored byte.
- R5: 0xFFFB returns the low byte of MEM_END and 0xFFFC returns its high byte. Both are read-only.
- R6: 0xFFFD returns the low byte of `tick_cnt` and 0xFFFE returns its high byte, each taken in the cycle of the read.
- R7: 0xFFF9 (low byte) and 0xFFFA (high byte) form a read-write stack ceiling. While in `ST_RUN`, if `stack_ptr` equals a non-zero ceiling, the block faults with exit code 0x04. A ceiling of 0 never faults. A newly written ceiling is compared from the next cycle onward.
- R8: 0xFFFF returns the exit code, which is 0x00 until a fault occurs.
- R9: 0xFF00 is a read-write scratch byte.
- R10: `fault` is high for exactly one cycle. In `ST_HALTED` there are no further faults, writes are ignored, `exit_code` holds its value, and reads return 0x00 except at 0xFFFF, which still returns the exit code.
- R11: If an access violation and a stack-ceiling match occur in the same cycle, the access code (0x01 or 0x02) wins. If `rd_en` and `wr_en` are both high, only the write is performed and checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Byte address of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| stack_ptr | input | 16 | Current stack pointer of the processor |
| tick_cnt | input | 16 | Running clock-tick count |
| rd_data | output | 8 | Registered read data |
| fault | output | 1 | One-cycle halt pulse |
| exit_code | output | 8 | Recorded exit code |

## Verification
An access violation and a stack-ceiling match can both occur in the same cycle. The bench provokes this by writing a non-zero ceiling, then presenting a stack pointer equal to it together with a read of address 0x0000 in a single cycle. The expected outcome is a single fault pulse carrying code 0x01 rather than 0x04. A second overlap is a read and a write strobe raised together: the bench checks that the written byte lands and that the read returns 0.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_RAM,
        RG_IO,
        RG_LIM_LO,
        RG_LIM_HI,
        RG_SIZE_LO,
        RG_SIZE_HI,
        RG_TICK_LO,
        RG_TICK_HI,
        RG_EXIT
    } region_e;

    typedef enum logic [0:0] {
        ST_RUN,
        ST_HALTED
    } state_e;

    localparam logic [7:0] CODE_OK    = 8'h00;
    localparam logic [7:0] CODE_RD    = 8'h01;
    localparam logic [7:0] CODE_WR    = 8'h02;
    localparam logic [7:0] CODE_STACK = 8'h04;

    localparam logic [15:0] A_IO      = 16'hFF00;
    localparam logic [15:0] A_LIM_LO  = 16'hFFF9;
    localparam logic [15:0] A_LIM_HI  = 16'hFFFA;
    localparam logic [15:0] A_SIZE_LO = 16'hFFFB;
    localparam logic [15:0] A_SIZE_HI = 16'hFFFC;
    localparam logic [15:0] A_TICK_LO = 16'hFFFD;
    localparam logic [15:0] A_TICK_HI = 16'hFFFE;
    localparam logic [15:0] A_EXIT    = 16'hFFFF;
    localparam logic [15:0] A_RAM_LO  = 16'h0002;

endpackage

// File: rtl/memmap_decode.sv
module memmap_decode
    import memmap_pkg::*;
#(
    parameter logic [15:0] MEM_END = 16'h00FF
) (
    input  logic [15:0] addr,
    output region_e     region,
    output logic        can_rd,
    output logic        can_wr
);

    always_comb begin
        region = RG_NONE;
        if (addr >= A_RAM_LO && addr <= MEM_END) begin
            region = RG_RAM;
        end else begin
            unique case (addr)
                A_IO:      region = RG_IO;
                A_LIM_LO:  region = RG_LIM_LO;
                A_LIM_HI:  region = RG_LIM_HI;
                A_SIZE_LO: region = RG_SIZE_LO;
                A_SIZE_HI: region = RG_SIZE_HI;
                A_TICK_LO: region = RG_TICK_LO;
                A_TICK_HI: region = RG_TICK_HI;
                A_EXIT:    region = RG_EXIT;
                default:   region = RG_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (region)
            RG_RAM, RG_IO, RG_LIM_LO, RG_LIM_HI: begin
                can_rd = 1'b1;
                can_wr = 1'b1;
            end
            RG_SIZE_LO, RG_SIZE_HI, RG_TICK_LO, RG_TICK_HI, RG_EXIT: begin
                can_rd = 1'b1;
                can_wr = 1'b0;
            end
            default: begin
                can_rd = 1'b0;
                can_wr = 1'b0;
            end
        endcase
    end

    // R3: no-access region never grants a right
    always_comb begin
        assert_none_closed_R3: assert (!(region == RG_NONE && (can_rd || can_wr)));
    end

endmodule

// File: rtl/memmap_ram.sv
module memmap_ram #(
    parameter logic [15:0] MEM_END = 16'h00FF,
    localparam int DEPTH = int'(MEM_END) + 1,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [15:0]   addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] idx;

    assign idx   = addr[IW-1:0];
    assign rdata = mem[idx];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    // R4: a RAM write is only ever issued inside the RAM window
    assert_ram_write_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (addr >= 16'h0002 && addr <= MEM_END));

endmodule

// File: rtl/memmap_special.sv
module memmap_special (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_lim_lo,
    input  logic        we_lim_hi,
    input  logic        we_io,
    input  logic [7:0]  wdata,
    input  logic [15:0] stack_ptr,
    output logic [15:0] limit,
    output logic [7:0]  scratch,
    output logic        stack_hit
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit   <= '0;
            scratch <= '0;
        end else begin
            if (we_lim_lo) limit[7:0]  <= wdata;
            if (we_lim_hi) limit[15:8] <= wdata;
            if (we_io)     scratch     <= wdata;
        end
    end

    assign stack_hit = (limit != 16'h0000) && (stack_ptr == limit);

    // R7: a zero ceiling means unlimited
    assert_zero_limit_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == 16'h0000) |-> !stack_hit);

endmodule

// File: rtl/memmap_guard.sv
module memmap_guard
    import memmap_pkg::*;
#(
    parameter logic [15:0] MEM_END = 16'h00FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [15:0] stack_ptr,
    input  logic [15:0] tick_cnt,
    output logic [7:0]  rd_data,
    output logic        fault,
    output logic [7:0]  exit_code
);

    state_e      st_q, st_d;
    region_e     region;
    logic        can_rd, can_wr;
    logic        rd_act, wr_act;
    logic        bad_rd, bad_wr, stack_hit;
    logic        fault_d;
    logic [7:0]  code_d, rdata_d, ram_rdata, scratch;
    logic [15:0] limit;
    logic        ram_we, we_lim_lo, we_lim_hi, we_io, commit;
    logic [7:0]  rd_data_q, exit_q;
    logic        fault_q;

    memmap_decode #(.MEM_END(MEM_END)) u_decode (
        .addr   (addr),
        .region (region),
        .can_rd (can_rd),
        .can_wr (can_wr)
    );

    memmap_ram #(.MEM_END(MEM_END)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (addr),
        .wdata (wr_data),
        .rdata (ram_rdata)
    );

    memmap_special u_special (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_lim_lo (we_lim_lo),
        .we_lim_hi (we_lim_hi),
        .we_io     (we_io),
        .wdata     (wr_data),
        .stack_ptr (stack_ptr),
        .limit     (limit),
        .scratch   (scratch),
        .stack_hit (stack_hit)
    );

    // a write wins over a read raised in the same cycle
    assign wr_act = wr_en;
    assign rd_act = rd_en && !wr_en;
    assign bad_rd = rd_act && !can_rd;
    assign bad_wr = wr_act && !can_wr;
    assign commit = (st_q == ST_RUN) && wr_act && can_wr;

    assign ram_we    = commit && (region == RG_RAM);
    assign we_lim_lo = commit && (region == RG_LIM_LO);
    assign we_lim_hi = commit && (region == RG_LIM_HI);
    assign we_io     = commit && (region == RG_IO);

    // next state and outputs
    always_comb begin
        st_d    = st_q;
        fault_d = 1'b0;
        code_d  = exit_q;
        rdata_d = 8'h00;
        unique case (st_q)
            ST_RUN: begin
                if (bad_wr || bad_rd || stack_hit) begin
                    st_d    = ST_HALTED;
                    fault_d = 1'b1;
                    code_d  = bad_wr ? CODE_WR : (bad_rd ? CODE_RD : CODE_STACK);
                end else if (rd_act) begin
                    unique case (region)
                        RG_RAM:     rdata_d = ram_rdata;
                        RG_IO:      rdata_d = scratch;
                        RG_LIM_LO:  rdata_d = limit[7:0];
                        RG_LIM_HI:  rdata_d = limit[15:8];
                        RG_SIZE_LO: rdata_d = MEM_END[7:0];
                        RG_SIZE_HI: rdata_d = MEM_END[15:8];
                        RG_TICK_LO: rdata_d = tick_cnt[7:0];
                        RG_TICK_HI: rdata_d = tick_cnt[15:8];
                        RG_EXIT:    rdata_d = exit_q;
                        default:    rdata_d = 8'h00;
                    endcase
                end
            end
            ST_HALTED: begin
                if (rd_act && region == RG_EXIT) begin
                    rdata_d = exit_q;
                end
            end
            default: st_d = ST_HALTED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= 8'h00;
            fault_q   <= 1'b0;
            exit_q    <= CODE_OK;
        end else begin
            rd_data_q <= rdata_d;
            fault_q   <= fault_d;
            exit_q    <= code_d;
        end
    end

    assign rd_data   = rd_data_q;
    assign fault     = fault_q;
    assign exit_code = exit_q;

    // R10: the halt pulse lasts one cycle
    assert_fault_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R10: the exit code is frozen once halted
    assert_exit_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALTED) |=> $stable(exit_code));

    // R3: a fault always carries one of the defined codes and zero data
    assert_fault_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ((exit_code == CODE_RD || exit_code == CODE_WR || exit_code == CODE_STACK)
                   && rd_data == 8'h00));

    // R7: a ceiling match with no access faults with the stack code
    assert_stack_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && stack_hit && !rd_en && !wr_en) |=> (fault && exit_code == CODE_STACK));

    // R10: no stored byte changes while halted
    assert_halt_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALTED) |-> !(ram_we || we_lim_lo || we_lim_hi || we_io));

endmodule

// File: tb/memmap_guard_bench.sv
module memmap_guard_bench;

    localparam int CLK_P = 10;
    localparam int NV    = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] stack_ptr = '0;
    logic [15:0] tick_cnt = 16'hBEEF;
    logic [7:0]  rd_data;
    logic        fault;
    logic [7:0]  exit_code;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    memmap_guard u_memmap_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .stack_ptr (stack_ptr),
        .tick_cnt  (tick_cnt),
        .rd_data   (rd_data),
        .fault     (fault),
        .exit_code (exit_code)
    );

    // {wr, rd, addr, wdata, expected rd_data}
    localparam logic [33:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h0002, 8'h5A, 8'h00},  // R2
        {1'b1, 1'b0, 16'h00FF, 8'hA5, 8'h00},  // R2
        {1'b0, 1'b1, 16'h0002, 8'h00, 8'h5A},  // R2
        {1'b0, 1'b1, 16'h00FF, 8'h00, 8'hA5},  // R2
        {1'b0, 1'b1, 16'hFFFB, 8'h00, 8'hFF},  // R5
        {1'b0, 1'b1, 16'hFFFC, 8'h00, 8'h00},  // R5
        {1'b0, 1'b1, 16'hFFFD, 8'h00, 8'hEF},  // R6
        {1'b0, 1'b1, 16'hFFFE, 8'h00, 8'hBE},  // R6
        {1'b1, 1'b0, 16'hFF00, 8'h3C, 8'h00},  // R9
        {1'b0, 1'b1, 16'hFF00, 8'h00, 8'h3C},  // R9
        {1'b1, 1'b0, 16'hFFF9, 8'h34, 8'h00},  // R7
        {1'b1, 1'b0, 16'hFFFA, 8'h12, 8'h00},  // R7
        {1'b0, 1'b1, 16'hFFF9, 8'h00, 8'h34},  // R7
        {1'b0, 1'b1, 16'hFFFA, 8'h00, 8'h12},  // R7
        {1'b0, 1'b1, 16'hFFFF, 8'h00, 8'h00},  // R8
        {1'b1, 1'b1, 16'h0010, 8'h77, 8'h00},  // R11
        {1'b0, 1'b1, 16'h0010, 8'h00, 8'h77}   // R11
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; stack_ptr = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one access, return after the edge that registers it
    task automatic acc(input logic w, input logic r, input logic [15:0] a, input logic [7:0] d);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic expect_fault(input string req, input logic [7:0] code);
        check(req, {15'd0, fault}, 16'd1);
        check(req, {8'd0, exit_code}, {8'd0, code});
        check(req, {8'd0, rd_data}, 16'h0000);
    endtask

    initial begin
        do_reset();
        check("R1 rd_data", {8'd0, rd_data}, 16'h0000);
        check("R1 fault", {15'd0, fault}, 16'd0);
        check("R1 exit", {8'd0, exit_code}, 16'h0000);
        acc(1'b0, 1'b1, 16'hFFF9, 8'h00);
        check("R1 limit", {8'd0, rd_data}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:8]);
            check($sformatf("R2/R5-R9/R11 vec %0d data", i), {8'd0, rd_data}, {8'd0, VEC[i][7:0]});
            check($sformatf("R2/R5-R9/R11 vec %0d fault", i), {15'd0, fault}, 16'd0);
        end

        // R3: no-access reads
        begin
            logic [15:0] bad_a [5] = '{16'h0000, 16'h0001, 16'h0100, 16'hFF01, 16'hFFF8};
            for (int k = 0; k < 5; k++) begin
                do_reset();
                acc(1'b0, 1'b1, bad_a[k], 8'h00);
                expect_fault($sformatf("R3 read %h", bad_a[k]), 8'h01);
            end
        end

        // R4: writes to read-only and no-access bytes
        begin
            logic [15:0] ro_a [4] = '{16'hFFFB, 16'hFFFF, 16'h0001, 16'hFF80};
            for (int k = 0; k < 4; k++) begin
                do_reset();
                acc(1'b1, 1'b0, ro_a[k], 8'h99);
                expect_fault($sformatf("R4 write %h", ro_a[k]), 8'h02);
            end
        end
        do_reset();
        acc(1'b0, 1'b1, 16'hFFFB, 8'h00);
        check("R4 size untouched", {8'd0, rd_data}, 16'h00FF);

        // R10: halted behaviour
        do_reset();
        acc(1'b1, 1'b0, 16'h0002, 8'h11);
        acc(1'b0, 1'b1, 16'h0000, 8'h00);
        expect_fault("R10 enter halt", 8'h01);
        acc(1'b1, 1'b0, 16'h0002, 8'h99);
        check("R10 single pulse", {15'd0, fault}, 16'd0);
        acc(1'b0, 1'b1, 16'h0000, 8'h00);
        check("R10 no refault", {15'd0, fault}, 16'd0);
        check("R10 code held", {8'd0, exit_code}, 16'h0001);
        acc(1'b0, 1'b1, 16'h0002, 8'h00);
        check("R10 read zero", {8'd0, rd_data}, 16'h0000);
        acc(1'b0, 1'b1, 16'hFFFF, 8'h00);
        check("R8 exit readable", {8'd0, rd_data}, 16'h0001);
        do_reset();
        acc(1'b0, 1'b1, 16'h0002, 8'h00);
        check("R10 write ignored", {8'd0, rd_data}, 16'h0011);

        // R7: ceiling 0 never faults
        do_reset();
        stack_ptr = 16'h0000;
        repeat (3) @(negedge clk);
        check("R7 zero ceiling", {15'd0, fault}, 16'd0);

        // R7: ceiling hit
        acc(1'b1, 1'b0, 16'hFFF9, 8'h40);
        acc(1'b1, 1'b0, 16'hFFFA, 8'h00);
        check("R7 no early fault", {15'd0, fault}, 16'd0);
        stack_ptr = 16'h0040;
        @(negedge clk);
        check("R7 stack fault", {15'd0, fault}, 16'd1);
        check("R7 stack code", {8'd0, exit_code}, 16'h0004);

        // R11: collision of access fault and ceiling hit
        do_reset();
        acc(1'b1, 1'b0, 16'hFFF9, 8'h40);
        stack_ptr = 16'h0040;
        acc(1'b0, 1'b1, 16'h0000, 8'h00);
        check("R11 one fault", {15'd0, fault}, 16'd1);
        check("R11 access code wins", {8'd0, exit_code}, 16'h0001);
        @(negedge clk);
        check("R11 single pulse", {15'd0, fault}, 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule